// File: doc/BRIEF.md
# I2C Multi-Address Slave Recognizer

This block watches an I2C bus as a slave and decides whether the first byte after a START condition is addressed to it. SCL and SDA enter from the pins asynchronously. They pass through a synchronizer, and edge detection then runs in the system clock domain. After a START, the block shifts in seven address bits, most significant first, followed by the direction bit. It compares the address against four programmable slots. Each slot has its own don't-care mask and its own general-call enable. When a slot matches, the block pulls SDA low for the acknowledge clock. It then reports that a match occurred, which slot matched and the transfer direction. Every complete nine-clock byte of an accepted transfer is copied into a receive buffer.

A small write port loads the slot addresses and masks. The block does not generate SCL, stretch the clock, act as a master or arbitrate. It also does not acknowledge data bytes; that belongs to the logic that consumes the match.

The controller has five states:

- `S_IDLE`: bus free.
- `S_ADDR`: shifting in the address byte.
- `S_ACK`: driving the acknowledge.
- `S_DATA`: receiving the bytes of an accepted transfer.
- `S_SKIP`: ignoring a transfer that no slot matched.

The transitions are:

- START moves from any state to `S_ADDR`.
- STOP moves from any state to `S_IDLE`.
- In `S_ADDR`, the falling SCL edge after the eighth bit moves to `S_ACK` when a slot matches, or to `S_SKIP` when none does.
- In `S_ACK`, the falling SCL edge after the ninth bit moves to `S_DATA`.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: START (SDA falls while SCL is high) begins address reception from any state. STOP (SDA rises while SCL is high) returns the block to idle and clears `match`. After reset, `match`, `match_slot`, `match_read`, `ack_drive` and `rx_byte` are all 0.
- R2: The first byte after START is shifted in on rising SCL edges, most significant bit first. Its upper seven bits are the address. Its eighth bit is the direction, reported on `match_read` (1 = read).
- R3: Write port layout:
  - Writing `cfg_sel` 0 to 3 stores slot `cfg_sel`. The address goes in `cfg_data[7:1]` and the general-call enable in `cfg_data[0]`.
  - Writing `cfg_sel` 4 to 7 stores the mask of slot `cfg_sel-4` from `cfg_data[7:1]`.
  - A mask bit of 1 makes that address bit don't-care.
  - A slot matches a nonzero address when the two agree on every unmasked bit.
- R4: The received address 0000000 matches a slot only when that slot's general-call enable is 1. The slot's mask is never applied to this comparison.
- R5: When several slots match, the lowest-numbered matching slot is reported.
- R6: On a match, `ack_drive` is 1 from the falling SCL edge that ends the eighth bit until the falling edge that ends the ninth bit. At all other times it is 0.
- R7: On a match, `match` becomes 1 at the ninth rising SCL edge, together with `match_slot` and `match_read`. These hold until the next START or STOP.
- R8: With no match, `ack_drive` stays 0 and `match` stays 0. All further bits are ignored, with `rx_byte` left unchanged, until the next START.
- R9: In an accepted transfer, `rx_byte` takes the byte's eight bits at the ninth rising SCL edge of every byte, the address byte included.
- R10: A repeated START restarts address reception, even in the middle of a byte, and the new address is judged on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| cfg_we | input | 1 | Write strobe for slot configuration |
| cfg_sel | input | 3 | Configuration entry select (0-3 address, 4-7 mask) |
| cfg_data | input | 8 | Configuration write data |
| ack_drive | output | 1 | 1 = pull SDA low (acknowledge) |
| match | output | 1 | Address byte was accepted |
| match_slot | output | 2 | Lowest matching slot index |
| match_read | output | 1 | Direction bit of the accepted transfer (1 = read) |
| rx_byte | output | 8 | Last complete byte received |

## Verification
The bench drives real START, bit, acknowledge and STOP waveforms. It sends addresses that hit one slot exactly, hit only through a mask, hit two slots at once (which separates priority from plain matching), and hit no slot at all. Several general-call bytes are sent: with general call disabled everywhere, with a fully masked slot that has general call disabled, and with a slot that has general call enabled. Together these show that masking never leaks into the general-call comparison. A byte sent after a miss shows that `rx_byte` is frozen. Repeated STARTs, one after a skipped transfer and one in the middle of an address, show that reception restarts cleanly.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ACK,
        S_DATA,
        S_SKIP
    } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slot_match.sv
module i2c_slot_match #(
    parameter int NSLOT = 4,
    parameter int AW    = 7,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic [AW-1:0] rx_addr,
    input  logic [AW-1:0] slot_addr [NSLOT],
    input  logic [AW-1:0] slot_mask [NSLOT],
    input  logic          slot_gc   [NSLOT],
    output logic          hit,
    output logic [SW-1:0] hit_idx
);
    logic [NSLOT-1:0] raw_hit;
    logic             is_gc;

    assign is_gc = (rx_addr == '0);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign raw_hit[g] = is_gc ? slot_gc[g]
                                  : (((rx_addr ^ slot_addr[g]) & ~slot_mask[g]) == '0);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                hit     = 1'b1;
                hit_idx = SW'(i);
            end
        end
    end

    // R5: the reported slot matches and no lower slot does
    always_comb begin
        p_lowest_slot_r5: assert (!hit || (raw_hit[hit_idx] &&
            ((raw_hit & ((NSLOT'(1) << hit_idx) - NSLOT'(1))) == '0)));
    end
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
    import i2c_rx_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int AW    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic                       cfg_we,
    input  logic [$clog2(NSLOT):0]     cfg_sel,
    input  logic [AW:0]                cfg_data,
    output logic                       ack_drive,
    output logic                       match,
    output logic [$clog2(NSLOT)-1:0]   match_slot,
    output logic                       match_read,
    output logic [AW:0]                rx_byte
);
    localparam int SW = $clog2(NSLOT);
    localparam int BW = AW + 1;
    localparam logic [3:0] LAST_BIT = 4'(BW);
    localparam logic [3:0] ACK_BIT  = 4'(BW + 1);

    rx_state_t state, next_state;

    logic          sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [BW-1:0] shreg;
    logic [3:0]    bit_cnt;
    logic [AW-1:0] slot_addr [NSLOT];
    logic [AW-1:0] slot_mask [NSLOT];
    logic          slot_gc   [NSLOT];
    logic          hit;
    logic [SW-1:0] hit_idx, hit_idx_q;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_slot_match #(.NSLOT(NSLOT), .AW(AW), .SW(SW)) u_match (
        .rx_addr   (shreg[BW-1:1]),
        .slot_addr (slot_addr),
        .slot_mask (slot_mask),
        .slot_gc   (slot_gc),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    // Slot configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                slot_addr[i] <= '0;
                slot_mask[i] <= '0;
                slot_gc[i]   <= 1'b0;
            end
        end else if (cfg_we) begin
            if (!cfg_sel[SW]) begin
                slot_addr[cfg_sel[SW-1:0]] <= cfg_data[AW:1];
                slot_gc[cfg_sel[SW-1:0]]   <= cfg_data[0];
            end else begin
                slot_mask[cfg_sel[SW-1:0]] <= cfg_data[AW:1];
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        if (stop_evt) begin
            next_state = S_IDLE;
        end else if (start_evt) begin
            next_state = S_ADDR;
        end else begin
            unique case (state)
                S_IDLE: next_state = S_IDLE;
                S_ADDR: if (scl_fall && bit_cnt == LAST_BIT)
                            next_state = hit ? S_ACK : S_SKIP;
                S_ACK:  if (scl_fall && bit_cnt == ACK_BIT)
                            next_state = S_DATA;
                S_DATA: next_state = S_DATA;
                S_SKIP: next_state = S_SKIP;
            endcase
        end
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            hit_idx_q  <= '0;
            match      <= 1'b0;
            match_slot <= '0;
            match_read <= 1'b0;
            rx_byte    <= '0;
        end else if (start_evt || stop_evt) begin
            bit_cnt <= '0;
            match   <= 1'b0;
        end else begin
            unique case (state)
                S_ADDR: begin
                    if (scl_rise && bit_cnt < LAST_BIT) begin
                        shreg   <= {shreg[BW-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (scl_fall && bit_cnt == LAST_BIT) hit_idx_q <= hit_idx;
                end
                S_ACK: begin
                    if (scl_rise) begin
                        bit_cnt    <= ACK_BIT;
                        match      <= 1'b1;
                        match_slot <= hit_idx_q;
                        match_read <= shreg[0];
                        rx_byte    <= shreg;
                    end
                    if (scl_fall && bit_cnt == ACK_BIT) bit_cnt <= '0;
                end
                S_DATA: begin
                    if (scl_rise) begin
                        if (bit_cnt == LAST_BIT) begin
                            rx_byte <= shreg;
                            bit_cnt <= '0;
                        end else begin
                            shreg   <= {shreg[BW-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                S_IDLE, S_SKIP: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        ack_drive = (state == S_ACK);
    end

    // R6: acknowledge only begins right after a falling SCL edge
    p_ack_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drive) |-> $past(scl_fall));

    // R1: STOP clears the match flag
    p_stop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !match);

    // R7: a match appears only out of the acknowledge phase, on a rising SCL
    p_match_from_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match) |-> ($past(state) == S_ACK && $past(scl_rise)));

    // R7: reported slot holds while the match holds
    p_slot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && $past(match)) |-> $stable(match_slot));

    // R9: buffer moves only on a rising SCL edge
    p_buf_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> $past(scl_rise));

    // R8: skipped transfer never acknowledges
    p_skip_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP) |-> (!ack_drive && !match));
endmodule

// File: tb/test_i2c_addr_recognizer.sv
module test_i2c_addr_recognizer;
    localparam int HOLD = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;
    logic       ack_drive, match, match_read;
    logic [1:0] match_slot;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [6:0] m_addr [4];
    logic [6:0] m_mask [4];
    logic       m_gc   [4];
    logic       e_match = 0, e_read = 0;
    logic [1:0] e_slot = 0;
    logic [7:0] e_rx = 0;

    always #10 clk = ~clk;

    i2c_addr_recognizer i_i2c_addr_recognizer (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .ack_drive(ack_drive), .match(match), .match_slot(match_slot),
        .match_read(match_read), .rx_byte(rx_byte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic d);
        scl = c;
        sda = d;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        if (!sel[2]) begin m_addr[sel[1:0]] = d[7:1]; m_gc[sel[1:0]] = d[0]; end
        else m_mask[sel[1:0]] = d[7:1];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [2:0] model_hit(input logic [6:0] a);
        for (int i = 0; i < 4; i++) begin
            if (a == 7'd0 ? m_gc[i] : (((a ^ m_addr[i]) & ~m_mask[i]) == 7'd0))
                return {1'b1, 2'(i)};
        end
        return 3'b000;
    endfunction

    task automatic do_start();
        if (scl == 1'b0) step(0, 1);
        step(1, 1);
        step(1, 0);
        step(0, 0);
        e_match = 0;
    endtask

    task automatic do_stop();
        step(0, 0);
        step(1, 0);
        step(1, 1);
        e_match = 0;
        chk("R1 stop clears match", 8'(match), 8'(e_match));
    endtask

    task automatic send_bit(input logic b);
        step(0, b);
        step(1, b);
        step(0, b);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw);
        logic [2:0] h;
        logic [7:0] by;
        h  = model_hit(a);
        by = {a, rw};
        for (int i = 7; i >= 0; i--) send_bit(by[i]);
        chk("R6 ack in ninth low", 8'(ack_drive), 8'(h[2]));
        step(0, 1);
        step(1, 1);
        chk("R6 ack in ninth high", 8'(ack_drive), 8'(h[2]));
        if (h[2]) begin
            e_match = 1; e_slot = h[1:0]; e_read = rw; e_rx = by;
        end
        chk("R7 match flag", 8'(match), 8'(e_match));
        step(0, 1);
        chk("R6 ack released", 8'(ack_drive), 8'd0);
        chk("R7 match held", 8'(match), 8'(e_match));
        if (h[2]) begin
            chk("R5 slot index", 8'(match_slot), 8'(e_slot));
            chk("R2 direction", 8'(match_read), 8'(e_read));
        end
        chk("R9 address byte buffer", rx_byte, e_rx);
    endtask

    task automatic send_data(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        step(0, 1);
        chk("R8 no ack on data", 8'(ack_drive), 8'd0);
        step(1, 1);
        step(0, 1);
        if (e_match) e_rx = v;
        chk("R9 data buffer", rx_byte, e_rx);
        chk("R7 match kept over data", 8'(match), 8'(e_match));
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_mask[i] = 0; m_gc[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 reset match", 8'(match), 8'd0);
        chk("R1 reset ack", 8'(ack_drive), 8'd0);
        chk("R1 reset slot", 8'(match_slot), 8'd0);
        chk("R1 reset dir", 8'(match_read), 8'd0);
        chk("R1 reset buffer", rx_byte, 8'd0);

        cfg(3'd0, {7'h50, 1'b0});
        cfg(3'd1, {7'h20, 1'b0});
        cfg(3'd5, {7'h03, 1'b0});
        cfg(3'd2, {7'h21, 1'b0});
        cfg(3'd3, {7'h3A, 1'b0});

        // R2: exact match write, then a data byte
        do_start(); send_addr(7'h50, 1'b0); send_data(8'h5C); do_stop();
        // R5: slots 1 and 2 both match, read
        do_start(); send_addr(7'h21, 1'b1); do_stop();
        // R3: only masked slot matches
        do_start(); send_addr(7'h22, 1'b0); send_data(8'hC3);
        // R10: repeated start into a miss; R8: following data ignored
        do_start(); send_addr(7'h11, 1'b0); send_data(8'h99);
        chk("R8 miss keeps match low", 8'(match), 8'd0);
        // R10: repeated start after skip
        do_start(); send_addr(7'h3A, 1'b1); do_stop();

        // R4: general call with no enable
        do_start(); send_addr(7'h00, 1'b0); do_stop();
        cfg(3'd7, {7'h7F, 1'b0});
        do_start(); send_addr(7'h00, 1'b0); do_stop();
        // R3: fully masked slot 3 catches anything nonzero
        do_start(); send_addr(7'h44, 1'b1); do_stop();
        cfg(3'd2, {7'h21, 1'b1});
        // R4: general call with slot 2 enabled
        do_start(); send_addr(7'h00, 1'b0); send_data(8'h06); do_stop();

        // R10: repeated start in mid-address
        do_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        do_start(); send_addr(7'h50, 1'b1); do_stop();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule